// File: doc/BRIEF.md
# Ternary Operand Fault Checker

This block sits beside a 32-bit adder and watches the operand pair that enters it. It holds a small set of ternary cubes, where each bit is 0, 1 or don't-care, that describe operand patterns known to excite a defect in the adder. Some cubes may be deliberately widened so that the set needs fewer entries. When an operand pair with a valid strobe matches any stored cube, the block raises a registered recovery flag one cycle later. The flag works in parallel with the adder and adds nothing to its critical path.

The cube table has no address decoder. A one-hot write token walks through the entries, so cubes are written in order, one per accepted load beat, starting at entry 0. A start pulse empties the table and begins a new fill. The fill ends when every entry has been written or when an end pulse arrives. This lets the table be loaded at power-on and replaced later, when new faulty patterns are found.

Top module: `tcam_op_checker`

## Requirements
- R1: After reset, `recover` and `load_done` are both low and the table holds no valid entry.
- R2: The checked vector is `{op_a, op_b}`, with `op_a` in bits 63:32. A vector bit whose `load_care` bit is 0 matches either value. A bit whose care bit is 1 matches only when it equals the stored `load_value` bit.
- R3: While a fill is in progress, each cycle with `load_valid` high writes the next entry, in order from entry 0. Every entry written this way takes part in matching.
- R4: Load beats after all N_ENTRIES entries have been written are ignored. `load_done` goes high in the cycle after the last entry is written.
- R5: A `load_end` pulse during a fill ends the fill, and `load_done` is high in the next cycle.
- R6: If the fill is complete and `op_valid` is high with a vector that matches at least one valid entry, `recover` is high in the next cycle. Otherwise `recover` is low in the next cycle.
- R7: `recover` stays low while a fill is in progress and after any cycle in which `op_valid` is low, even when the operands would match.
- R8: A `load_start` pulse clears every valid bit and rewinds the write order to entry 0. `load_done` and `recover` are low in the following cycle, and cubes from earlier fills no longer match.
- R9: A `load_valid` beat given while no fill is in progress writes nothing, so its cube never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | OP_W | First adder operand |
| op_b | input | OP_W | Second adder operand |
| load_start | input | 1 | Empty the table and begin a fill |
| load_valid | input | 1 | Load beat carrying one cube |
| load_value | input | 2*OP_W | Cube bit values |
| load_care | input | 2*OP_W | Cube care mask, 1 = bit must match |
| load_end | input | 1 | Finish the fill early |
| load_done | output | 1 | Fill is complete and matching is enabled |
| recover | output | 1 | Registered recovery flag |

## Verification
The bench builds the block with N_ENTRIES set to 4 and the default operand width of 32 bits. The small table lets a directed test fill every entry and then push one more beat, so the overflow, the last-entry write and the automatic completion can all be checked in a few cycles. Full-width operands keep the split between `op_a` and `op_b` and the don't-care masks at realistic positions. The tests cover partial fills closed by the end pulse, refills that must erase older cubes, and probes given during a fill and without a valid strobe.

// File: rtl/tcam_op_checker.sv
module tcam_op_checker #(
  parameter int N_ENTRIES = 32,
  parameter int OP_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              load_start,
  input  logic              load_valid,
  input  logic [2*OP_W-1:0] load_value,
  input  logic [2*OP_W-1:0] load_care,
  input  logic              load_end,
  output logic              load_done,
  output logic              recover
);
  localparam int VEC_W = 2 * OP_W;

  logic [VEC_W-1:0]     cube_val  [N_ENTRIES];
  logic [VEC_W-1:0]     cube_care [N_ENTRIES];
  logic [N_ENTRIES-1:0] cube_ok;
  logic [N_ENTRIES-1:0] token;
  logic [N_ENTRIES-1:0] hit;
  logic                 filling;

  wire [VEC_W-1:0] probe  = {op_a, op_b};
  wire             accept = filling && load_valid && !load_start && |token;
  wire             last   = accept && token[N_ENTRIES-1];

  genvar i;
  generate
    for (i = 0; i < N_ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (accept && token[i]) begin
          cube_val[i]  <= load_value & load_care;
          cube_care[i] <= load_care;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n || load_start) cube_ok[i] <= 1'b0;
        else if (accept && token[i]) cube_ok[i] <= 1'b1;
      end

      assign hit[i] = cube_ok[i] && (((probe ^ cube_val[i]) & cube_care[i]) == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || load_start) begin
      token   <= N_ENTRIES'(1);
      filling <= 1'b1;
    end else if (filling) begin
      if (accept) token <= token << 1;
      if (last || load_end) filling <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) recover <= 1'b0;
    else        recover <= !filling && !load_start && op_valid && |hit;
  end

  assign load_done = !filling;
endmodule

// File: rtl/tcam_op_checker_sva.sv
module tcam_op_checker_sva #(
  parameter int N_ENTRIES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic                 load_start,
  input logic                 load_end,
  input logic                 load_done,
  input logic                 recover,
  input logic [N_ENTRIES-1:0] token
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !recover && !load_done);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(token));

  p_end_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_end && !load_start |=> load_done);

  p_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> $past(op_valid) && $past(load_done));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_done && !recover);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && !load_start |=> load_done);
endmodule

bind tcam_op_checker tcam_op_checker_sva #(.N_ENTRIES(N_ENTRIES)) u_sva (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .load_start(load_start),
  .load_end(load_end), .load_done(load_done), .recover(recover), .token(token)
);

// File: tb/tcam_op_checker_tb.sv
`timescale 1ns/1ps
module tcam_op_checker_tb;
  localparam int N = 4;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic load_start = 1'b0, load_valid = 1'b0, load_end = 1'b0;
  logic [2*W-1:0] load_value = '0, load_care = '0;
  logic load_done, recover;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tcam_op_checker #(.N_ENTRIES(N), .OP_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .load_start(load_start), .load_valid(load_valid), .load_value(load_value),
    .load_care(load_care), .load_end(load_end), .load_done(load_done), .recover(recover)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic pulse_start();
    load_start = 1'b1; @(negedge clk); load_start = 1'b0;
  endtask

  task automatic pulse_end();
    load_end = 1'b1; @(negedge clk); load_end = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [2*W-1:0] care);
    load_valid = 1'b1; load_value = {a, b}; load_care = care;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic probe(input logic [W-1:0] a, input logic [W-1:0] b, input logic v,
                       input logic exp, input string what);
    op_valid = v; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    check(recover, exp, what);
  endtask

  task automatic t_reset();
    check(recover, 1'b0, "R1 recover after reset");
    check(load_done, 1'b0, "R1 load_done after reset");
    probe(32'h0, 32'h0, 1'b1, 1'b0, "R7 no flag while filling after reset");
  endtask

  task automatic t_basic_fill();
    pulse_start();
    check(load_done, 1'b0, "R8 done low after start");
    push(32'h12345678, 32'h9abcdef0, '1);
    probe(32'h12345678, 32'h9abcdef0, 1'b1, 1'b0, "R7 flag forced low mid-fill");
    push(32'hABCD0000, 32'h0, {32'hFFFF0000, 32'h0});
    push(32'h0, 32'h1, {32'h0, 32'h1});
    pulse_end();
    check(load_done, 1'b1, "R5 end pulse completes fill");
  endtask

  task automatic t_match();
    probe(32'h12345678, 32'h9abcdef0, 1'b1, 1'b1, "R6 exact cube hit");
    probe(32'h12345678, 32'h9abcdef2, 1'b1, 1'b0, "R2 one cared bit differs");
    probe(32'hABCD1234, 32'h5555AAAA, 1'b1, 1'b1, "R2 don't-care bits ignored");
    probe(32'hABCE1234, 32'h5555AAAA, 1'b1, 1'b0, "R2 cared upper A bit differs");
    probe(32'hDEADBEEF, 32'h00000007, 1'b1, 1'b1, "R2 odd B matches third cube");
    probe(32'hDEADBEEF, 32'h00000006, 1'b1, 1'b0, "R6 no cube matches");
    probe(32'h12345678, 32'h9abcdef0, 1'b0, 1'b0, "R7 op_valid low blocks flag");
  endtask

  task automatic t_refill();
    pulse_start();
    check(recover, 1'b0, "R8 recover low after start");
    push(32'h1, 32'h2, '1);
    pulse_end();
    probe(32'h12345678, 32'h9abcdef0, 1'b1, 1'b0, "R8 old cube erased");
    probe(32'hDEADBEEF, 32'h00000007, 1'b1, 1'b0, "R8 old wide cube erased");
    probe(32'h1, 32'h2, 1'b1, 1'b1, "R3 new entry 0 matches");
  endtask

  task automatic t_overflow();
    pulse_start();
    for (int k = 0; k < N; k++) begin
      check(load_done, 1'b0, "R4 done low before table full");
      push(32'd10 + 32'(k), 32'h0, '1);
    end
    check(load_done, 1'b1, "R4 done after last entry");
    push(32'd99, 32'h0, '1);
    probe(32'd99, 32'h0, 1'b1, 1'b0, "R4 extra beat ignored");
    probe(32'd10, 32'h0, 1'b1, 1'b1, "R3 first entry matches");
    probe(32'd10 + 32'(N - 1), 32'h0, 1'b1, 1'b1, "R3 last entry matches");
  endtask

  task automatic t_idle_load();
    push(32'd55, 32'h0, '1);
    probe(32'd55, 32'h0, 1'b1, 1'b0, "R9 beat outside fill ignored");
    check(load_done, 1'b1, "R9 done unchanged by stray beat");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_fill();
    t_match();
    t_refill();
    t_overflow();
    t_idle_load();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule